// File: doc/BRIEF.md
# Change-of-State Interrupt Controller

This block watches 24 isolated digital inputs and 8 TTL/CMOS inputs for transitions. Each input is first brought into the local clock domain. Edges are then latched into sticky status bits. The inputs are handled as four groups of eight. Each group has its own rising-edge enable and its own falling-edge enable. An edge sets a status bit only when its group has that polarity enabled.

A single level interrupt is raised while any status bit is set. Software reads the status bytes over a byte-wide register bus. It acknowledges events by writing the value it read back to the same offset, which clears only the bits that are 1 in the written byte. The same bus also gives the synchronised level of every input and read/write access to the enable byte.

Top module: `cos_irq_ctrl`

## Requirements
- R1: After reset the enable byte reads 0x00, all status bytes read 0x00 and `irq` is low.
- R2: Offset 0xE holds the enable byte, which reads back the value last written. Bit g (0..3) enables rising edges for group g, and bit g+4 enables falling edges for group g. Group 0 is isolated inputs 0-7, group 1 is inputs 8-15, group 2 is inputs 16-23, and group 3 is TTL/CMOS inputs 0-7.
- R3: A 0-to-1 transition on an input whose group has its rising enable set makes that input's status bit 1.
- R4: A 1-to-0 transition on an input whose group has its falling enable set makes that input's status bit 1.
- R5: A transition whose polarity is not enabled for its group leaves the status bit unchanged.
- R6: Status bits are sticky. Isolated status is read at 0x8, 0x9 and 0xA, with bit i of byte k standing for input 8k+i. TTL/CMOS status is read at 0xB, with bit i standing for TTL/CMOS input i.
- R7: A write to 0x8..0xB clears exactly the status bits of that byte that are 1 in the written data. The other bits are kept.
- R8: If an enabled edge on an input lands in the same cycle as a clear write to its status bit, the bit stays 1.
- R9: `irq` is high exactly while at least one status bit is 1. It falls only as the result of a clear write.
- R10: Offsets 0x4, 0x5 and 0x6 read the synchronised isolated input levels, in the same bit order as R6. Offset 0x7 reads the TTL/CMOS levels.
- R11: A read returns its data one cycle after `bus_rd`, with `bus_rvalid` high for that cycle only. Offsets that are not mapped read 0x00.
- R12: Writes to the input-level offsets or to unmapped offsets change neither the enable byte nor any status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iso_in | input | 24 | Isolated inputs (asynchronous) |
| ttl_in | input | 8 | TTL/CMOS inputs (asynchronous) |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| irq | output | 1 | Level interrupt, high while any status bit is set |

## Verification
The bench lands a falling edge in the very cycle a clear write targets the same bit. A design that lets the clear win would lose that event and read 0x00 instead of 0x01.

It clears one bit of a two-bit status byte and checks that the neighbour survives. A design that clears the whole byte, or that clears using the bits not written, shows up here. It also checks that `irq` stays high until the last set bit is acknowledged.

Edges of a disabled polarity are applied with the other polarity enabled, including under the mixed enable pattern 0xA5. This catches designs that swap the rising and falling nibbles or misplace the group index. Writes to the input-level and unmapped offsets are followed by reads of the enable byte and the status bytes, which exposes any decoder that aliases them.

// File: rtl/cos_irq_pkg.sv
package cos_irq_pkg;

   localparam int unsigned DATA_W = 8;
   localparam int unsigned ADDR_W = 4;

   // Offsets; the group index is added to a base, so the order matters.
   localparam logic [ADDR_W-1:0] RAW_BASE = 4'h4;
   localparam logic [ADDR_W-1:0] STS_BASE = 4'h8;
   localparam logic [ADDR_W-1:0] EN_ADDR  = 4'hE;

   typedef enum logic [1:0] {
      ACC_NONE,
      ACC_RAW,
      ACC_STS,
      ACC_EN
   } acc_kind_e;

endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] d_sync
);

   if (STAGES < 2) begin : g_bad_stages
      $error("cos_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= d_async;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign d_sync = stg[STAGES-1];

endmodule

// File: rtl/cos_edge_latch.sv
module cos_edge_latch #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] level,
   input  logic             en_rise,
   input  logic             en_fall,
   input  logic [WIDTH-1:0] clr,
   output logic [WIDTH-1:0] status
);

   logic [WIDTH-1:0] prev_q;
   logic [WIDTH-1:0] rise;
   logic [WIDTH-1:0] fall;
   logic [WIDTH-1:0] hit;

   assign rise = level & ~prev_q;
   assign fall = ~level & prev_q;
   assign hit  = ({WIDTH{en_rise}} & rise) | ({WIDTH{en_fall}} & fall);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         status <= '0;
      end else begin
         prev_q <= level;
         // A fresh edge takes priority over a clear of the same bit.
         status <= (status & ~clr) | hit;
      end
   end

endmodule

// File: rtl/cos_regs.sv
module cos_regs
   import cos_irq_pkg::*;
#(
   parameter int unsigned NGRP    = 4,
   parameter int unsigned GROUP_W = 8,
   localparam int unsigned ALL_W  = NGRP * GROUP_W,
   localparam int unsigned SEL_W  = (NGRP > 1) ? $clog2(NGRP) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [ALL_W-1:0]  raw_flat,
   input  logic [ALL_W-1:0]  sts_flat,
   output logic [2*NGRP-1:0] en_q,
   output logic [ALL_W-1:0]  clr_flat,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_rvalid
);

   acc_kind_e        kind;
   logic [SEL_W-1:0] grp_sel;
   logic [DATA_W-1:0] rd_mux;

   always_comb begin
      kind    = ACC_NONE;
      grp_sel = '0;
      if (bus_addr == EN_ADDR) kind = ACC_EN;
      for (int g = 0; g < int'(NGRP); g++) begin
         if (int'(bus_addr) == int'(STS_BASE) + g) begin
            kind    = ACC_STS;
            grp_sel = SEL_W'(g);
         end
         if (int'(bus_addr) == int'(RAW_BASE) + g) begin
            kind    = ACC_RAW;
            grp_sel = SEL_W'(g);
         end
      end
   end

   for (genvar g = 0; g < NGRP; g++) begin : g_clr
      assign clr_flat[g*GROUP_W +: GROUP_W] =
         (bus_wr && kind == ACC_STS && grp_sel == SEL_W'(g)) ? bus_wdata : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       en_q <= '0;
      else if (bus_wr && kind == ACC_EN) en_q <= bus_wdata;
   end

   always_comb begin
      unique case (kind)
         ACC_EN:  rd_mux = en_q;
         ACC_STS: rd_mux = sts_flat[int'(grp_sel)*GROUP_W +: GROUP_W];
         ACC_RAW: rd_mux = raw_flat[int'(grp_sel)*GROUP_W +: GROUP_W];
         default: rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rvalid <= 1'b0;
         bus_rdata  <= '0;
      end else begin
         bus_rvalid <= bus_rd;
         if (bus_rd) bus_rdata <= rd_mux;
      end
   end

endmodule

// File: rtl/cos_irq_ctrl.sv
module cos_irq_ctrl
   import cos_irq_pkg::*;
#(
   parameter int unsigned ISO_GROUPS  = 3,
   parameter int unsigned TTL_GROUPS  = 1,
   parameter int unsigned GROUP_W     = 8,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned NGRP  = ISO_GROUPS + TTL_GROUPS,
   localparam int unsigned ISO_W = ISO_GROUPS * GROUP_W,
   localparam int unsigned TTL_W = TTL_GROUPS * GROUP_W,
   localparam int unsigned ALL_W = ISO_W + TTL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ISO_W-1:0]  iso_in,
   input  logic [TTL_W-1:0]  ttl_in,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_rvalid,
   output logic              irq
);

   if (GROUP_W != DATA_W) begin : g_bad_gw
      $error("cos_irq_ctrl: a group must fill one bus byte");
   end
   if (2 * NGRP != DATA_W) begin : g_bad_ngrp
      $error("cos_irq_ctrl: enable byte needs two bits per group");
   end
   if (int'(RAW_BASE) + int'(NGRP) > int'(STS_BASE)) begin : g_bad_map
      $error("cos_irq_ctrl: level and status windows overlap");
   end

   logic [ALL_W-1:0]  raw_flat;
   logic [ALL_W-1:0]  sts_flat;
   logic [ALL_W-1:0]  clr_flat;
   logic [2*NGRP-1:0] en_bits;

   cos_sync #(
      .WIDTH  (ALL_W),
      .STAGES (SYNC_STAGES)
   ) i_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async ({ttl_in, iso_in}),
      .d_sync  (raw_flat)
   );

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      cos_edge_latch #(
         .WIDTH (GROUP_W)
      ) i_latch (
         .clk     (clk),
         .rst_n   (rst_n),
         .level   (raw_flat[g*GROUP_W +: GROUP_W]),
         .en_rise (en_bits[g]),
         .en_fall (en_bits[NGRP + g]),
         .clr     (clr_flat[g*GROUP_W +: GROUP_W]),
         .status  (sts_flat[g*GROUP_W +: GROUP_W])
      );
   end

   cos_regs #(
      .NGRP    (NGRP),
      .GROUP_W (GROUP_W)
   ) i_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_addr   (bus_addr),
      .bus_wr     (bus_wr),
      .bus_rd     (bus_rd),
      .bus_wdata  (bus_wdata),
      .raw_flat   (raw_flat),
      .sts_flat   (sts_flat),
      .en_q       (en_bits),
      .clr_flat   (clr_flat),
      .bus_rdata  (bus_rdata),
      .bus_rvalid (bus_rvalid)
   );

   assign irq = |sts_flat;

endmodule

// File: rtl/cos_irq_ctrl_chk.sv
module cos_irq_ctrl_chk
   import cos_irq_pkg::*;
#(
   parameter int unsigned NGRP    = 4,
   parameter int unsigned GROUP_W = 8,
   localparam int unsigned ALL_W  = NGRP * GROUP_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              bus_rvalid,
   input logic              irq,
   input logic [2*NGRP-1:0] en_bits,
   input logic [ALL_W-1:0]  sts_flat
);

   logic en_wr;
   logic sts_wr;
   assign en_wr  = bus_wr && (bus_addr == EN_ADDR);
   assign sts_wr = bus_wr && (int'(bus_addr) >= int'(STS_BASE))
                          && (int'(bus_addr) <  int'(STS_BASE) + int'(NGRP));

   AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd |=> bus_rvalid); // R11
   AST_NO_SPURIOUS_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> !bus_rvalid); // R11
   AST_ENABLE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      en_wr |=> (en_bits == $past(bus_wdata))); // R2
   AST_ENABLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !en_wr |=> $stable(en_bits)); // R12
   AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !sts_wr |=> ((sts_flat & $past(sts_flat)) == $past(sts_flat))); // R6
   AST_IRQ_FALL_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(sts_wr)); // R9

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      AST_SET_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
         ((sts_flat[g*GROUP_W +: GROUP_W] & ~$past(sts_flat[g*GROUP_W +: GROUP_W])) != '0)
         |-> ($past(en_bits[g]) || $past(en_bits[NGRP + g]))); // R5
   end

endmodule

bind cos_irq_ctrl cos_irq_ctrl_chk #(
   .NGRP    (NGRP),
   .GROUP_W (GROUP_W)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_addr   (bus_addr),
   .bus_wr     (bus_wr),
   .bus_rd     (bus_rd),
   .bus_wdata  (bus_wdata),
   .bus_rvalid (bus_rvalid),
   .irq        (irq),
   .en_bits    (en_bits),
   .sts_flat   (sts_flat)
);

// File: tb/test_cos_irq_ctrl.sv
module test_cos_irq_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:0] iso_in = '0;
   logic [7:0]  ttl_in = '0;
   logic [3:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        bus_rvalid;
   logic        irq;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   typedef struct {
      logic [7:0] data;
      string      tag;
   } exp_t;
   exp_t exp_q[$];

   always #10 clk = ~clk;

   cos_irq_ctrl i_cos_irq_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .iso_in     (iso_in),
      .ttl_in     (ttl_in),
      .bus_addr   (bus_addr),
      .bus_wr     (bus_wr),
      .bus_rd     (bus_rd),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .bus_rvalid (bus_rvalid),
      .irq        (irq)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // Driver: push the expected value, then issue the read.
   task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
      exp_q.push_back('{data: e, tag: tag});
      bus_addr = a;
      bus_rd   = 1'b1;
      @(negedge clk);
      bus_rd   = 1'b0;
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   // Monitor: pop and compare as read data appears.
   always @(negedge clk) begin
      if (rst_n && bus_rvalid) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R11 unexpected rvalid", 1, 0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(bus_rdata == e.data, e.tag, bus_rdata, e.data);
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      check(irq == 1'b0, "R1 irq after reset", irq, 0);
      rd(4'hE, 8'h00, "R1 enable reset");
      rd(4'h8, 8'h00, "R1 status 0x8 reset");
      rd(4'hB, 8'h00, "R1 status 0xB reset");

      wr(4'hE, 8'h01);
      rd(4'hE, 8'h01, "R2 enable readback");
      check(bus_rvalid == 1'b1, "R11 rvalid one cycle after read", bus_rvalid, 1);
      @(negedge clk);
      check(bus_rvalid == 1'b0, "R11 rvalid single cycle", bus_rvalid, 0);

      iso_in[3] = 1'b1;
      settle();
      check(irq == 1'b1, "R9 irq on pending event", irq, 1);
      rd(4'h8, 8'h08, "R3 rising edge group 0");
      rd(4'h9, 8'h00, "R6 other group untouched");

      iso_in[3] = 1'b0;
      settle();
      rd(4'h8, 8'h08, "R5 falling edge disabled, sticky");
      iso_in[9] = 1'b1;
      settle();
      rd(4'h9, 8'h00, "R5 group 1 rising disabled");

      rd(4'h4, 8'h00, "R10 level 0x4");
      rd(4'h5, 8'h02, "R10 level 0x5");

      wr(4'hE, 8'hFF);
      iso_in[17:16] = 2'b11;
      ttl_in[5]     = 1'b1;
      settle();
      rd(4'hA, 8'h03, "R3 rising edge group 2");
      rd(4'hB, 8'h20, "R6 ttl status at 0xB");
      rd(4'h6, 8'h03, "R10 level 0x6");
      rd(4'h7, 8'h20, "R10 level 0x7");
      rd(4'h8, 8'h08, "R6 sticky across groups");

      wr(4'hA, 8'h01);
      rd(4'hA, 8'h02, "R7 partial clear keeps neighbour");
      wr(4'h8, 8'h08);
      wr(4'hB, 8'h20);
      check(irq == 1'b1, "R9 irq held while one bit set", irq, 1);
      wr(4'hA, 8'h02);
      check(irq == 1'b0, "R9 irq low after last clear", irq, 0);
      rd(4'hA, 8'h00, "R7 full clear");

      ttl_in[5] = 1'b0;
      settle();
      rd(4'hB, 8'h20, "R4 falling edge ttl group");
      wr(4'hB, 8'h20);

      // R8: clear write lands in the same cycle the new edge is latched.
      iso_in[0] = 1'b1;
      settle();
      iso_in[0] = 1'b0;
      @(negedge clk);
      @(negedge clk);
      wr(4'h8, 8'h01);
      rd(4'h8, 8'h01, "R8 edge beats same-cycle clear");
      wr(4'h8, 8'h01);
      rd(4'h8, 8'h00, "R7 clear after R8 case");

      wr(4'h4, 8'hFF);
      wr(4'h7, 8'hFF);
      wr(4'hC, 8'h00);
      rd(4'hE, 8'hFF, "R12 enable untouched by ignored writes");
      rd(4'h8, 8'h00, "R12 status untouched by ignored writes");
      rd(4'h4, 8'h00, "R12 level unaffected");
      rd(4'hC, 8'h00, "R11 unmapped read");
      rd(4'h0, 8'h00, "R11 unmapped read low");

      wr(4'hE, 8'hA5);
      rd(4'hE, 8'hA5, "R2 mixed enable readback");
      iso_in[9]  = 1'b0;
      iso_in[16] = 1'b0;
      ttl_in[1]  = 1'b1;
      settle();
      rd(4'h9, 8'h02, "R4 falling edge group 1");
      rd(4'hA, 8'h00, "R5 group 2 falling disabled");
      rd(4'hB, 8'h00, "R5 ttl rising disabled");

      repeat (3) @(negedge clk);
      check(exp_q.size() == 0, "R11 all reads answered", exp_q.size(), 0);
      finish_run();
   end

endmodule